// File: doc/BRIEF.md
# Serial Divide-by-Three Residue Tracker

The block reads a binary number one bit per clock, most significant bit first, and keeps the remainder of the value received so far when divided by three. Each accepted bit doubles the previous remainder and adds the new bit, modulo three. Three states are enough for this, one per remainder.

A producer raises the bit-valid strobe together with each data bit. A synchronous clear starts a new number. The registered remainder and a divisible-by-three flag are visible one cycle after the bit that produced them. An asynchronous active-low reset sets the block to the empty number, whose remainder is zero.

Top module: `mod3_serial_residue`

## Requirements
- R1: While `rst_n` is low, and after it is released, the remainder output `rem` reads 0 and `div3` reads 1 until a bit or clear is taken.
- R2: From remainder 0, an accepted bit 0 leaves the remainder at 0 and an accepted bit 1 gives remainder 1, visible on the next cycle.
- R3: From remainder 1, an accepted bit 0 gives remainder 2 and an accepted bit 1 gives remainder 0.
- R4: From remainder 2, an accepted bit 0 gives remainder 1 and an accepted bit 1 leaves the remainder at 2.
- R5: A cycle with `bit_vld` low and `clr` low leaves `rem` unchanged, whatever `bit_in` carries.
- R6: `clr` high forces remainder 0 on the next cycle, and it takes priority over a valid bit in the same cycle.
- R7: `div3` is 1 exactly when `rem` is 0. The remainder is encoded as a plain binary value: 00 for 0, 01 for 1, 10 for 2. The value 11 is never produced.
- R8: After any sequence of up to 32 accepted bits following a clear, `rem` equals the value of those bits, read MSB first, modulo three.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear, starts a new number |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial data bit, MSB first |
| rem | output | 2 | Remainder of the value so far, modulo three |
| div3 | output | 1 | High when the value so far is divisible by three |

## Verification
A clear and a valid data bit can arrive in the same cycle. The bench provokes this by raising `clr` together with `bit_vld` and a 1 bit, from each nonzero remainder. It expects remainder 0 on the next cycle, not the value the bit would have produced. The scoreboard also interleaves idle cycles with toggling `bit_in` inside random words, to show that the held remainder is not disturbed.

// File: rtl/mod3_pkg.sv
package mod3_pkg;
  localparam int RES_W = 2;
  typedef logic [RES_W-1:0] res_t;
  localparam res_t RES_ZERO = 2'b00;
  localparam res_t RES_ONE  = 2'b01;
  localparam res_t RES_TWO  = 2'b10;
endpackage

// File: rtl/mod3_step.sv
module mod3_step
  import mod3_pkg::*;
(
  input  res_t cur,
  input  logic din,
  output res_t nxt
);
  // new remainder = (2*old + bit) mod 3
  always_comb begin
    case (cur)
      RES_ZERO: nxt = din ? RES_ONE  : RES_ZERO;
      RES_ONE:  nxt = din ? RES_ZERO : RES_TWO;
      RES_TWO:  nxt = din ? RES_TWO  : RES_ONE;
      default:  nxt = RES_ZERO;  // illegal code recovers to zero
    endcase
  end
endmodule

// File: rtl/mod3_decode.sv
module mod3_decode
  import mod3_pkg::*;
(
  input  res_t cur,
  output res_t rem_o,
  output logic zero_o
);
  always_comb begin
    rem_o  = (cur == 2'b11) ? RES_ZERO : cur;
    zero_o = (rem_o == RES_ZERO);
  end
endmodule

// File: rtl/mod3_serial_residue.sv
module mod3_serial_residue
  import mod3_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       bit_vld,
  input  logic       bit_in,
  output logic [1:0] rem,
  output logic       div3
);
  res_t state_q;
  res_t step_nxt;
  res_t state_d;
  logic state_en;

  mod3_step u_step (
    .cur (state_q),
    .din (bit_in),
    .nxt (step_nxt)
  );

  // clock enable and next-state selection; clear wins over data
  always_comb begin
    state_en = clr | bit_vld;
    state_d  = clr ? RES_ZERO : step_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RES_ZERO;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  mod3_decode u_dec (
    .cur    (state_q),
    .rem_o  (rem),
    .zero_o (div3)
  );

  a_r2_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rem == 2'd0 && bit_vld && !clr) |=> (rem == {1'b0, $past(bit_in)}));
  a_r3_from_one: assert property (@(posedge clk) disable iff (!rst_n)
    (rem == 2'd1 && bit_vld && !clr) |=> (rem == ($past(bit_in) ? 2'd0 : 2'd2)));
  a_r4_from_two: assert property (@(posedge clk) disable iff (!rst_n)
    (rem == 2'd2 && bit_vld && !clr) |=> (rem == ($past(bit_in) ? 2'd2 : 2'd1)));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_vld && !clr) |=> $stable(rem));
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rem == 2'd0 && div3));
  a_r7_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != 2'b11) && (div3 == (state_q == RES_ZERO)));
endmodule

// File: tb/test_mod3_serial_residue.sv
module test_mod3_serial_residue;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 100000;

  logic clk = 1'b0;
  logic rst_n, clr, bit_vld, bit_in;
  logic [1:0] rem;
  logic div3;

  int n_checks = 0;
  int n_fail = 0;
  bit run_done = 1'b0;
  int run_val = 0;

  logic [1:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mod3_serial_residue i_mod3_serial_residue (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bit_vld(bit_vld),
    .bit_in(bit_in), .rem(rem), .div3(div3)
  );

  task automatic check(input string tag, input logic [1:0] exp);
    n_checks++;
    if (rem !== exp || div3 !== (exp == 2'd0)) begin
      n_fail++;
      $display("FAIL %s: rem=%0d div3=%0d expected rem=%0d div3=%0d",
               tag, rem, div3, exp, (exp == 2'd0));
    end
  endtask

  // monitor: one expected item per driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) check(tag_q.pop_front(), exp_q.pop_front());
    end
  end

  task automatic drive(input logic c, input logic v, input logic b, input string tag);
    @(negedge clk);
    clr = c; bit_vld = v; bit_in = b;
    if (c) run_val = 0;
    else if (v) run_val = (2 * run_val + int'(b)) % 3;
    exp_q.push_back(run_val[1:0]);
    tag_q.push_back(tag);
  endtask

  task automatic idle_all();
    @(negedge clk);
    clr = 0; bit_vld = 0; bit_in = 0;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0; clr = 0; bit_vld = 0; bit_in = 0;
    repeat (3) @(negedge clk);
    check("R1 during reset", 2'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", 2'd0);

    // R2
    drive(0, 1, 0, "R2 0->0");
    drive(0, 1, 1, "R2 0->1");
    // R3
    drive(0, 1, 0, "R3 1->2");
    drive(0, 1, 0, "R4 2->1");
    drive(0, 1, 1, "R3 1->0");
    drive(0, 1, 1, "R2 0->1");
    drive(0, 1, 0, "R3 1->2");
    drive(0, 1, 1, "R4 2->2");
    // R5: hold with toggling data
    drive(0, 0, 1, "R5 hold");
    drive(0, 0, 0, "R5 hold");
    drive(0, 0, 1, "R5 hold");
    drive(0, 1, 0, "R4 2->1 after hold");
    // R6: clear collides with a valid 1 bit from remainder 1
    drive(1, 1, 1, "R6 clear beats bit at rem 1");
    drive(0, 1, 1, "R2 0->1");
    drive(0, 1, 0, "R3 1->2");
    drive(1, 1, 1, "R6 clear beats bit at rem 2");
    drive(1, 0, 0, "R6 clear alone");
    idle_all();

    // R7/R8: random words
    for (int w = 0; w < 200; w++) begin
      int len;
      len = $urandom_range(1, 32);
      drive(1, 0, 0, "R6 word start");
      for (int k = 0; k < len; k++) begin
        if ($urandom_range(0, 4) == 0) drive(0, 0, 1'($urandom), "R5 idle in word");
        drive(0, 1, 1'($urandom), "R8 R7 running residue");
      end
    end
    idle_all();
    // async reset mid-number
    drive(0, 1, 1, "R2 before reset");
    idle_all();
    rst_n = 0;
    #1;
    check("R1 async reset", 2'd0);
    @(negedge clk);
    rst_n = 1;
    run_val = 0;
    @(negedge clk);
    check("R1 after second release", 2'd0);
    run_done = 1'b1;
  end

  initial begin
    fork
      wait (run_done);
      begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule